// File: doc/BRIEF.md
# Translation Miss Register Preloader

This block sits beside a software-managed translation buffer. When a data access misses, it fills a small set of assist registers so the miss handler finds most of a new translation entry already prepared. The handler then only has to supply the physical side and issue the entry write. The block keeps three working registers and one defaults register. The selection register names the target buffer, the target entry and the next entry to use. The attribute register holds the page size. The page register holds the page number. The defaults register supplies the buffer choice and page size that a miss should assume.

Victim choice in the two-way set-associative buffer is round-robin. A one-bit pointer names the current victim. A miss copies that pointer into the entry-select field and places its inverse in the next-victim field. The pointer itself advances only when software writes the set-associative buffer at the entry the pointer names. All four registers can be read and written through a simple indexed register port. Index 0 is the selection register, 1 the attribute register, 2 the page register and 3 the defaults register.

Top module: `missAssistLoader`

## Requirements
- R1: After reset, all four registers read as zero and the victim pointer is 0.
- R2: A register-port write with no miss in the same cycle stores the write data into the register picked by the index: 0 selection, 1 attribute, 2 page, 3 defaults. A read at that index returns the stored value combinationally.
- R3: On a miss, selection bit 28 (buffer select) takes the value of defaults bit 28, using the value held before that cycle. Selection bits not named in R4 and R5 keep their values.
- R4: On a miss with defaults bit 28 equal to 0, selection bits 19:16 (entry select) load the victim pointer, zero-extended.
- R5: On a miss with defaults bit 28 equal to 0, selection bit 0 (next victim) loads the inverse of the victim pointer.
- R6: On a miss with defaults bit 28 equal to 1, selection bits 19:16 and bit 0 are unchanged.
- R7: On a miss, page bits 31:12 load address bits 31:12, and page bits 11:0 keep their values.
- R8: On a miss, attribute bits 11:8 (page size) load defaults bits 11:8, and all other attribute bits are kept.
- R9: The victim pointer toggles, one cycle later, only when software writes the set-associative buffer (target 0) at entry index equal to the pointer. A miss, a write with target 1 and a write at another entry leave it unchanged.
- R10: When a miss and a register-port write to the selection, attribute or page register fall in the same cycle, the miss update wins and the write data is dropped. A write to the defaults register in that cycle still takes effect.
- R11: A miss never changes the defaults register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| missValid | input | 1 | One-cycle data translation miss strobe |
| missAddr | input | 32 | Faulting effective address |
| regWrEn | input | 1 | Register port write enable |
| regWrSel | input | 2 | Register port write index |
| regWrData | input | 32 | Register port write data |
| regRdSel | input | 2 | Register port read index |
| regRdData | output | 32 | Register port read data |
| entryWrValid | input | 1 | Software wrote a translation entry |
| entryWrTarget | input | 1 | Target buffer of that write (0 = set-associative) |
| entryWrIndex | input | 4 | Entry index of that write |
| victimPtr | output | 1 | Current round-robin victim |

## Verification
Directed misses are run with the defaults buffer-select bit both clear and set, and with the victim pointer at each value. This separates the victim-field loading from the buffer-select copy and shows that the fields are left alone when the select bit is 1. Entry writes are tried at the matching entry, at the other entry and with target 1, so that only a matching set-associative write moves the pointer. A same-cycle miss and register write to each index shows which registers the miss overrides. Random traffic then mixes misses, writes and entry writes against a bench model that checks all four registers and the pointer every cycle.

// File: rtl/missAssistPkg.sv
package missAssistPkg;
  localparam int unsigned REG_W      = 32;
  localparam int unsigned REG_COUNT  = 4;
  localparam int unsigned IDX_W      = $clog2(REG_COUNT);
  localparam int unsigned BUF_SEL_BIT = 28;
  localparam int unsigned ESEL_LSB   = 16;
  localparam int unsigned ESEL_W     = 4;
  localparam int unsigned NV_BIT     = 0;
  localparam int unsigned SIZE_LSB   = 8;
  localparam int unsigned SIZE_W     = 4;
  localparam int unsigned PAGE_LSB   = 12;

  typedef enum logic [IDX_W-1:0] {
    REG_SELECT = 2'd0,
    REG_ATTR   = 2'd1,
    REG_PAGE   = 2'd2,
    REG_DFLT   = 2'd3
  } regIdx_e;

  typedef struct packed {
    logic                 missLoad;
    logic                 pickVictim;
    logic [REG_COUNT-1:0] swWrite;
  } ctlStrobes_t;
endpackage

// File: rtl/missAssistCtl.sv
module missAssistCtl
  import missAssistPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                missValid,
  input  logic                regWrEn,
  input  logic [IDX_W-1:0]    regWrSel,
  input  logic                dfltBufSel,
  input  logic                entryWrValid,
  input  logic                entryWrTarget,
  input  logic [ESEL_W-1:0]   entryWrIndex,
  output ctlStrobes_t         strobes,
  output logic                victim
);
  logic advance;

  assign advance = entryWrValid && !entryWrTarget &&
                   (entryWrIndex == ESEL_W'(victim));

  assign strobes.missLoad   = missValid;
  assign strobes.pickVictim = missValid && !dfltBufSel;

  for (genvar i = 0; i < REG_COUNT; i++) begin : g_wrDecode
    if (i == int'(REG_DFLT)) begin : g_dflt
      assign strobes.swWrite[i] = regWrEn && (regWrSel == IDX_W'(i));
    end else begin : g_work
      assign strobes.swWrite[i] = regWrEn && (regWrSel == IDX_W'(i)) && !missValid;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)        victim <= 1'b0;
    else if (advance) victim <= ~victim;
  end

  assert_one_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes.swWrite));
  assert_victim_step_R9: assert property (@(posedge clk) disable iff (!rstN)
    advance |=> victim != $past(victim));
  assert_victim_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !advance |=> $stable(victim));
endmodule

// File: rtl/missAssistData.sv
module missAssistData
  import missAssistPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobes_t        strobes,
  input  logic [REG_W-1:0]   missAddr,
  input  logic [REG_W-1:0]   wrData,
  input  logic [IDX_W-1:0]   rdSel,
  input  logic               victim,
  output logic [REG_W-1:0]   rdData,
  output logic               dfltBufSel
);
  logic [REG_W-1:0] regQ    [REG_COUNT];
  logic [REG_W-1:0] missNext[REG_COUNT];

  assign dfltBufSel = regQ[REG_DFLT][BUF_SEL_BIT];
  assign rdData     = regQ[rdSel];

  always_comb begin
    missNext[REG_SELECT] = regQ[REG_SELECT];
    missNext[REG_SELECT][BUF_SEL_BIT] = regQ[REG_DFLT][BUF_SEL_BIT];
    if (strobes.pickVictim) begin
      missNext[REG_SELECT][ESEL_LSB +: ESEL_W] = ESEL_W'(victim);
      missNext[REG_SELECT][NV_BIT]             = ~victim;
    end
    missNext[REG_ATTR] = regQ[REG_ATTR];
    missNext[REG_ATTR][SIZE_LSB +: SIZE_W] = regQ[REG_DFLT][SIZE_LSB +: SIZE_W];
    missNext[REG_PAGE] = {missAddr[REG_W-1:PAGE_LSB], regQ[REG_PAGE][PAGE_LSB-1:0]};
    missNext[REG_DFLT] = regQ[REG_DFLT];
  end

  for (genvar i = 0; i < REG_COUNT; i++) begin : g_reg
    if (i == int'(REG_DFLT)) begin : g_dflt
      always_ff @(posedge clk) begin
        if (!rstN)                  regQ[i] <= '0;
        else if (strobes.swWrite[i]) regQ[i] <= wrData;
      end
    end else begin : g_work
      always_ff @(posedge clk) begin
        if (!rstN)                   regQ[i] <= '0;
        else if (strobes.missLoad)   regQ[i] <= missNext[i];
        else if (strobes.swWrite[i]) regQ[i] <= wrData;
      end
    end
  end

  assert_bufsel_copy_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.missLoad |=> regQ[REG_SELECT][BUF_SEL_BIT] == $past(regQ[REG_DFLT][BUF_SEL_BIT]));
  assert_esel_load_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.pickVictim |=> regQ[REG_SELECT][ESEL_LSB +: ESEL_W] == ESEL_W'($past(victim)));
  assert_nv_load_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.pickVictim |=> regQ[REG_SELECT][NV_BIT] != $past(victim));
  assert_victim_fields_kept_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.missLoad && !strobes.pickVictim) |=>
      ($stable(regQ[REG_SELECT][ESEL_LSB +: ESEL_W]) && $stable(regQ[REG_SELECT][NV_BIT])));
  assert_page_load_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.missLoad |=> (regQ[REG_PAGE][REG_W-1:PAGE_LSB] == $past(missAddr[REG_W-1:PAGE_LSB]))
                      && $stable(regQ[REG_PAGE][PAGE_LSB-1:0]));
  assert_size_load_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.missLoad |=> regQ[REG_ATTR][SIZE_LSB +: SIZE_W] == $past(regQ[REG_DFLT][SIZE_LSB +: SIZE_W]));
  assert_dflt_kept_R11: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.missLoad && !strobes.swWrite[REG_DFLT]) |=> $stable(regQ[REG_DFLT]));
endmodule

// File: rtl/missAssistLoader.sv
module missAssistLoader
  import missAssistPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                missValid,
  input  logic [REG_W-1:0]    missAddr,
  input  logic                regWrEn,
  input  logic [IDX_W-1:0]    regWrSel,
  input  logic [REG_W-1:0]    regWrData,
  input  logic [IDX_W-1:0]    regRdSel,
  output logic [REG_W-1:0]    regRdData,
  input  logic                entryWrValid,
  input  logic                entryWrTarget,
  input  logic [ESEL_W-1:0]   entryWrIndex,
  output logic                victimPtr
);
  ctlStrobes_t strobes;
  logic        dfltBufSel;

  missAssistCtl uCtl (
    .clk          (clk),
    .rstN         (rstN),
    .missValid    (missValid),
    .regWrEn      (regWrEn),
    .regWrSel     (regWrSel),
    .dfltBufSel   (dfltBufSel),
    .entryWrValid (entryWrValid),
    .entryWrTarget(entryWrTarget),
    .entryWrIndex (entryWrIndex),
    .strobes      (strobes),
    .victim       (victimPtr)
  );

  missAssistData uData (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .missAddr  (missAddr),
    .wrData    (regWrData),
    .rdSel     (regRdSel),
    .victim    (victimPtr),
    .rdData    (regRdData),
    .dfltBufSel(dfltBufSel)
  );
endmodule

// File: tb/missAssistLoader_test.sv
module missAssistLoader_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        missValid = 1'b0;
  logic [31:0] missAddr = '0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regWrSel = '0;
  logic [31:0] regWrData = '0;
  logic [1:0]  regRdSel = '0;
  logic [31:0] regRdData;
  logic        entryWrValid = 1'b0;
  logic        entryWrTarget = 1'b0;
  logic [3:0]  entryWrIndex = '0;
  logic        victimPtr;

  int unsigned checks = 0;
  int unsigned fails = 0;
  logic [31:0] model [4];
  logic        modelVic;
  bit          finished = 0;

  missAssistLoader uut (.*);

  always #5 clk = ~clk;

  function automatic logic [31:0] missSel(logic [31:0] cur, logic [31:0] dflt, logic vic);
    logic [31:0] r = cur;
    r[28] = dflt[28];
    if (!dflt[28]) begin
      r[19:16] = {3'b000, vic};
      r[0] = ~vic;
    end
    return r;
  endfunction

  function automatic logic [31:0] missAttr(logic [31:0] cur, logic [31:0] dflt);
    logic [31:0] r = cur;
    r[11:8] = dflt[11:8];
    return r;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic checkAll(string tag);
    for (int i = 0; i < 4; i++) begin
      regRdSel = 2'(i);
      #1;
      check(tag, regRdData, model[i]);
    end
    check(tag, {31'b0, victimPtr}, {31'b0, modelVic});
  endtask

  // Drive one cycle of stimulus at the current mid-cycle point, update the model, check after the edge.
  task automatic step(logic miss, logic [31:0] addr, logic we, logic [1:0] ws, logic [31:0] wd,
                      logic ev, logic et, logic [3:0] ei, string tag);
    logic [31:0] nxt [4];
    logic nv;
    missValid = miss; missAddr = addr; regWrEn = we; regWrSel = ws; regWrData = wd;
    entryWrValid = ev; entryWrTarget = et; entryWrIndex = ei;
    for (int i = 0; i < 4; i++) nxt[i] = model[i];
    if (we) nxt[ws] = wd;
    if (miss) begin
      nxt[0] = missSel(model[0], model[3], modelVic);
      nxt[1] = missAttr(model[1], model[3]);
      nxt[2] = {addr[31:12], model[2][11:0]};
    end
    nv = modelVic;
    if (ev && !et && ei == {3'b000, modelVic}) nv = ~modelVic;
    @(posedge clk);
    #1;
    missValid = 0; regWrEn = 0; entryWrValid = 0;
    for (int i = 0; i < 4; i++) model[i] = nxt[i];
    modelVic = nv;
    checkAll(tag);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 4; i++) model[i] = '0;
    modelVic = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1: values under reset
    checkAll("R1");
    rstN = 1'b1;
    @(posedge clk); #1;
    checkAll("R1");

    // R2: plain writes to each index
    step(0, 0, 1, 2'd0, 32'hA5A5_0F0F, 0, 0, 0, "R2");
    step(0, 0, 1, 2'd1, 32'h1234_5678, 0, 0, 0, "R2");
    step(0, 0, 1, 2'd2, 32'hCAFE_0ABC, 0, 0, 0, "R2");
    step(0, 0, 1, 2'd3, 32'h0000_0700, 0, 0, 0, "R2");
    // R3 R4 R5 R7 R8: miss with defaults select 0, victim 0
    step(1, 32'hDEAD_B123, 0, 0, 0, 0, 0, 0, "R3 R4 R5 R7 R8");
    // R9: entry write at wrong index, target 1, then matching
    step(0, 0, 0, 0, 0, 1, 0, 4'd1, "R9");
    step(0, 0, 0, 0, 0, 1, 1, 4'd0, "R9");
    step(1, 32'h0000_1000, 0, 0, 0, 0, 0, 0, "R9");
    step(0, 0, 0, 0, 0, 1, 0, 4'd0, "R9");
    // R4 R5 with victim 1
    step(1, 32'h8765_4FFF, 0, 0, 0, 0, 0, 0, "R4 R5");
    // R6 R3: defaults select 1, fields kept
    step(0, 0, 1, 2'd3, 32'h1000_0A00, 0, 0, 0, "R2");
    step(0, 0, 1, 2'd0, 32'h000F_0001, 0, 0, 0, "R2");
    step(1, 32'h1111_1FFF, 0, 0, 0, 0, 0, 0, "R6 R3");
    // R10: miss with same-cycle write to each index; R11 on defaults
    step(1, 32'h2222_2000, 1, 2'd0, 32'hFFFF_FFFF, 0, 0, 0, "R10");
    step(1, 32'h3333_3000, 1, 2'd1, 32'hFFFF_FFFF, 0, 0, 0, "R10");
    step(1, 32'h4444_4000, 1, 2'd2, 32'hFFFF_FFFF, 0, 0, 0, "R10");
    step(1, 32'h5555_5000, 1, 2'd3, 32'h0000_0300, 0, 0, 0, "R10");
    step(1, 32'h6666_6000, 0, 0, 0, 0, 0, 0, "R11");

    // Random mix for R10 and the rest
    for (int n = 0; n < 400; n++) begin
      logic [31:0] r = $urandom;
      step(r[0] & r[1], $urandom, r[2], r[4:3], $urandom,
           r[5], r[6] & r[7], {r[8] & r[9], 2'b00, r[10]}, "R10 random");
    end
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule